// File: doc/BRIEF.md
# Phase-Selectable Demodulation Clock Generator

This block turns a fast synchronous clock into a square-wave demodulation signal at the carrier rate, whose phase is set by a small digital code. It serves as the feedback phase DAC of a phase-domain sigma-delta loop: the loop's multi-bit quantizer code picks one of eight evenly spaced phase shifts, and the resulting square wave steers an up/down counter that demodulates and integrates the carrier. The fast clock runs at 32 times the carrier, so one fast-clock cycle is exactly 11.25 degrees of carrier phase.

A free-running 5-bit phase counter marks the carrier period. Every phase-shifted copy of the square wave is derived from that counter by comparing it with a code-dependent offset, so the high and low halves are whole numbers of fast-clock cycles and the duty cycle is exactly 50%. The code is captured once per period, at the period boundary, and a one-cycle tick marks the start of each period, for use as the quantizer sample strobe. The sample rate therefore equals the carrier rate.

Top module: `demod_phase_gen`

## Requirements
- R1: While rst_ni is low, demod_o and tick_o are both 0.
- R2: tick_o is high for exactly one clock cycle in every 32; the first tick is the cycle that follows the first rising clock edge after rst_ni goes high.
- R3: Every high pulse of demod_o lasts exactly 16 clock cycles; while the code does not change, each period has 16 high and 16 low cycles.
- R4: With applied code k (unsigned, 3 bits, values 0 to 7), demod_o rises exactly k+1 clock cycles after the cycle in which tick_o is high, a phase lag of (k+1) x 11.25 degrees, from 11.25 to 90 degrees.
- R5: The code applied to a period is the value on code_i at the rising edge one cycle before tick_o goes high; a change of code_i at any other time leaves the current period's waveform unchanged.
- R6: The first period after reset uses code 0, whatever value code_i holds.
- R7: demod_o is low in every cycle in which tick_o is high, so a code change never cuts or extends a high pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock, 32 cycles per carrier period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 3 | Phase code from the quantizer |
| demod_o | output | 1 | Phase-shifted 50% demodulation square wave |
| tick_o | output | 1 | One-cycle strobe at each period start |

## Verification
The hardest situation to reach is a code change that lands exactly on, just before or just after the single capture edge of a period, since only the edge one cycle before the tick counts. The stimulus walks the bench's own period position to the cycle before that edge, changes the code there, and changes it again right after the edge, then expects the first value for the whole period. Random code changes at random cycles, a sweep of all eight codes and alternation between the smallest and largest phase add the rest, and a reset with a nonzero code on the input checks that the first period still uses code 0.

// File: rtl/demod_phase_gen.sv
module demod_phase_gen #(
  parameter int CODE_W = 3,
  parameter int DIV_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              demod_o,
  output logic              tick_o
);

  localparam int PERIOD = 1 << DIV_W;
  localparam int HALF   = PERIOD / 2;
  localparam logic [DIV_W-1:0] LAST_POS = DIV_W'(PERIOD - 1);
  localparam logic [DIV_W-1:0] HALF_POS = DIV_W'(HALF);

  logic [DIV_W-1:0]  phase_cnt;
  logic [DIV_W-1:0]  tap_dly;
  logic [DIV_W-1:0]  tap_pos;
  logic [CODE_W-1:0] code_q;
  logic              demod_q;
  logic              tick_q;
  logic              wrap;

  assign wrap    = (phase_cnt == LAST_POS);
  assign tap_dly = DIV_W'(code_q) + DIV_W'(1);
  assign tap_pos = phase_cnt - tap_dly;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_cnt <= '0;
      code_q    <= '0;
      demod_q   <= 1'b0;
      tick_q    <= 1'b0;
    end else begin
      phase_cnt <= phase_cnt + DIV_W'(1);
      if (wrap) code_q <= code_i;
      tick_q    <= (phase_cnt == '0);
      demod_q   <= (tap_pos < HALF_POS);
    end
  end

  assign demod_o = demod_q;
  assign tick_o  = tick_q;

  logic [DIV_W:0] hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_run <= '0;
    else if (demod_q) hi_run <= hi_run + (DIV_W+1)'(1);
    else              hi_run <= '0;
  end

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q); // R2

  AST_LOW_AT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> !demod_q); // R7

  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_cnt != '0) |-> $stable(code_q)); // R5

  AST_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(demod_q) |-> (hi_run == (DIV_W+1)'(HALF))); // R3

endmodule

// File: tb/demod_phase_gen_tb.sv
module demod_phase_gen_tb;

  localparam int CLK_P = 10;
  localparam int PER   = 32;
  localparam int HALF  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] code_i = '0;
  logic       demod_o;
  logic       tick_o;

  int n_chk = 0;
  int n_fail = 0;
  int edge_n = 0;
  int exp_sel = 0;
  int cur_code = 0;
  int hi_len = 0;
  bit prev_demod = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  demod_phase_gen u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .code_i (code_i),
    .demod_o(demod_o),
    .tick_o (tick_o)
  );

  function automatic bit exp_tick(int n);
    return ((n - 1) % PER) == 0;
  endfunction

  function automatic bit exp_demod(int n, int s);
    int c = (n - 1) % PER;
    int d = s + 1;
    return (c >= d) && (c < d + HALF);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  task automatic set_code(int k);
    cur_code = k;
    code_i   = 3'(k);
  endtask

  task automatic run_cycles(int count, string tag, bit rnd);
    for (int i = 0; i < count; i++) begin
      bit ed;
      string t;
      @(posedge clk);
      edge_n++;
      if (edge_n % PER == 0) exp_sel = cur_code;
      @(negedge clk);
      t = (edge_n <= PER) ? "R6" : tag;
      check(tick_o == exp_tick(edge_n), "R2", tick_o, exp_tick(edge_n));
      ed = exp_demod(edge_n, exp_sel);
      check(demod_o == ed, t, demod_o, ed);
      if (tick_o) check(demod_o == 1'b0, "R7", demod_o, 0);
      if (demod_o) hi_len++;
      else if (prev_demod) begin
        check(hi_len == HALF, "R3", hi_len, HALF);
        hi_len = 0;
      end
      prev_demod = demod_o;
      if (rnd && ($urandom % 7 == 0)) set_code(int'($urandom % 8));
    end
  endtask

  task automatic do_reset(int k);
    @(negedge clk);
    rst_n = 1'b0;
    set_code(k);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tick_o == 1'b0, "R1", tick_o, 0);
    check(demod_o == 1'b0, "R1", demod_o, 0);
    rst_n      = 1'b1;
    edge_n     = 0;
    exp_sel    = 0;
    hi_len     = 0;
    prev_demod = 1'b0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(5);
    run_cycles(2 * PER, "R4", 1'b0);

    for (int k = 0; k < 8; k++) begin
      set_code(k);
      run_cycles(2 * PER, "R4", 1'b0);
    end

    for (int j = 0; j < 6; j++) begin
      set_code((j % 2 == 0) ? 7 : 0);
      run_cycles(PER, "R4", 1'b0);
    end

    run_cycles(40 * PER, "R5", 1'b1);

    for (int j = 0; j < 4; j++) begin
      while (edge_n % PER != PER - 1) run_cycles(1, "R5", 1'b0);
      set_code(j + 2);
      run_cycles(1, "R5", 1'b0);
      set_code(7 - j);
      run_cycles(PER - 3, "R5", 1'b0);
      set_code(0);
      run_cycles(3, "R5", 1'b0);
    end

    do_reset(7);
    run_cycles(3 * PER, "R4", 1'b0);

    report();
  end

endmodule